// File: doc/BRIEF.md
# Synchronous Burst SRAM Write Controller

This block is the write side of a pipelined synchronous burst static RAM with a processor-style control interface. Every control input is sampled on the rising clock edge. A write sequence can open through either of two address strobes. The processor strobe is gated by one chip enable. The controller strobe is not gated, but it still samples all three enables. The accepted address loads a burst counter. Later cycles either repeat the current word or step the counter within an aligned group of four words. Each beat writes the storage one byte lane at a time, under a global write input or under a byte-write enable with per-lane strobes.

The chip-enable decision is captured only when a strobe is accepted, and it holds until the next accepted strobe. A processor-strobed start never writes in its own address cycle: its byte strobes take effect from the next cycle. A selected cycle that writes nothing reads the word at that cycle's address. The word appears on the registered read output one cycle later, with a drive flag that stands for the output buffer. The flag is low after any write cycle and after any unselected cycle. The word count is set by `ADDR_W`. The full-size device uses 16, and the default is kept small.

Top module: `burst_sram_wr`

## Requirements
- R1: A processor strobe (`cpu_strobe_n`=0) accepted while `sel_gate_n`=0 loads `addr` into the burst counter, takes the select decision from the three enables, and writes no byte in that cycle, whatever the write inputs are.
- R2: A processor strobe seen while `sel_gate_n`=1 is ignored. When no controller strobe is present, the burst address and the selected state carry on exactly as if no strobe had been seen.
- R3: A controller strobe (`ctl_strobe_n`=0) loads `addr` whether `sel_gate_n` is high or low. If the device is selected, the same cycle writes at `addr`. When both strobes are low and `sel_gate_n`=0, the processor strobe wins.
- R4: All controls are active-low. The device is selected only if `sel_gate_n`, `sel_a_n` and `sel_b_n` are all 0. This is sampled only in a strobe cycle. A deselect holds until the next accepted strobe, and no write happens while it holds.
- R5: In a selected cycle with no strobe, `burst_adv_n`=0 adds one to the low two counter bits, wrapping inside the aligned group of four, and the beat uses the stepped address. With `burst_adv_n`=1 the beat uses the current address.
- R6: `wr_all_n`=0 writes all four lanes in a write-capable selected cycle, whatever `wr_byte_n` and `lane_wr_n` are.
- R7: With `wr_all_n`=1 and `wr_byte_n`=0, lane i (data bits 8i+7..8i) is written exactly when `lane_wr_n[i]`=0. With both `wr_all_n` and `wr_byte_n` high, nothing is written.
- R8: A selected cycle that writes no lane reads the word at its address. In the next cycle `rdata` holds that word, and `rdata_drive` is 1 if `out_en_n` was 0 in the read cycle.
- R9: `rdata_drive` is 0 in the cycle after any write cycle and in the cycle after any unselected cycle.
- R10: During and right after reset the device is unselected, and `rdata_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, used when a strobe is accepted |
| cpu_strobe_n | input | 1 | Processor address strobe, gated by `sel_gate_n` |
| ctl_strobe_n | input | 1 | Controller address strobe, not gated |
| burst_adv_n | input | 1 | Burst advance |
| wr_all_n | input | 1 | Global write of all lanes |
| wr_byte_n | input | 1 | Byte-write enable |
| lane_wr_n | input | LANES | Per-lane write strobes |
| sel_gate_n | input | 1 | Chip enable that also masks the processor strobe |
| sel_a_n | input | 1 | Chip enable, sampled on strobes only |
| sel_b_n | input | 1 | Chip enable, sampled on strobes only |
| out_en_n | input | 1 | Output enable for the read word |
| wdata | input | LANES*LANE_W | Write data for the current beat |
| rdata | output | LANES*LANE_W | Registered read word |
| rdata_drive | output | 1 | High when the read output is driven; low means high-impedance |

## Verification
The bench first fills the storage with known words. It then goes after five cases with targeted sequences:
- a processor strobe that arrives with its write inputs already asserted; a design that wrote in the address cycle would corrupt the loaded word;
- a processor strobe masked by the gating enable; a design that honoured it would jump to the new address;
- both strobes together; a design with the wrong priority would write on the controller path;
- a deselect on a strobe followed by write beats; a design that re-sampled the enables every cycle would write while unselected;
- a burst that starts on the last word of a group; a design that carried into the upper bits would leave the group.

Byte-lane masks are checked against hand-computed merged words. Constrained random traffic then mixes every strobe, enable and mask against a bench model.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
package burst_sram_pkg;
  // Kind of cycle seen at a clock edge.
  typedef enum logic [1:0] {
    CYC_IDLE   = 2'd0,  // no strobe, device not selected
    CYC_PSTART = 2'd1,  // processor strobe accepted
    CYC_CSTART = 2'd2,  // controller strobe accepted
    CYC_CONT   = 2'd3   // continuation beat of a selected sequence
  } cyc_kind_e;
endpackage

// File: rtl/bsr_ctrl.sv
`timescale 1ns/1ps
module bsr_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int LANES   = 4,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cpu_strobe_n,
  input  logic              ctl_strobe_n,
  input  logic              burst_adv_n,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              sel_gate_n,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [LANES-1:0]  wr_lanes,
  output logic              rd_en,
  output logic              active_q,
  output logic [ADDR_W-1:0] burst_q
);
  localparam logic [BURST_W-1:0] STEP = BURST_W'(1);

  cyc_kind_e          kind;
  logic               cpu_take;
  logic               sel_now;
  logic               cyc_sel;
  logic [LANES-1:0]   req_lanes;
  logic [ADDR_W-1:0]  stepped;

  // Next word inside the aligned burst group (low bits wrap).
  assign stepped = {burst_q[ADDR_W-1:BURST_W], burst_q[BURST_W-1:0] + STEP};

  always_comb begin
    cpu_take = !cpu_strobe_n && !sel_gate_n;
    sel_now  = !sel_gate_n && !sel_a_n && !sel_b_n;
    if (cpu_take)           kind = CYC_PSTART;
    else if (!ctl_strobe_n) kind = CYC_CSTART;
    else if (active_q)      kind = CYC_CONT;
    else                    kind = CYC_IDLE;
  end

  always_comb begin
    cyc_sel  = 1'b0;
    cyc_addr = burst_q;
    case (kind)
      CYC_PSTART, CYC_CSTART: begin
        cyc_sel  = sel_now;
        cyc_addr = addr;
      end
      CYC_CONT: begin
        cyc_sel  = 1'b1;
        cyc_addr = burst_adv_n ? burst_q : stepped;
      end
      default: begin
        cyc_sel  = 1'b0;
        cyc_addr = burst_q;
      end
    endcase
  end

  // Lane request: global write covers all lanes, else masked byte write.
  always_comb begin
    if (!wr_all_n)      req_lanes = '1;
    else if (!wr_byte_n) req_lanes = ~lane_wr_n;
    else                req_lanes = '0;
  end

  // The processor-strobed address cycle never writes.
  assign wr_lanes = (cyc_sel && kind != CYC_PSTART) ? req_lanes : '0;
  assign rd_en    = cyc_sel && (kind == CYC_PSTART || req_lanes == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      burst_q  <= '0;
    end else begin
      active_q <= cyc_sel;
      burst_q  <= cyc_addr;
    end
  end
endmodule

// File: rtl/bsr_lanes.sv
`timescale 1ns/1ps
module bsr_lanes #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES-1:0]          wr_lanes,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic                      rd_en,
  output logic [LANES*LANE_W-1:0]   rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  // One independent array per byte lane so each maps onto a block RAM.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_lanes[g]) store[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_en)       rd_q        <= store[addr];
    end

    assign rd_data[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/bsr_out.sv
`timescale 1ns/1ps
module bsr_out (
  input  logic clk,
  input  logic rst,
  input  logic rd_en,
  input  logic out_en_n,
  output logic drive_q
);
  // Output buffer is enabled only for a read with output enable low.
  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= rd_en && !out_en_n;
  end
endmodule

// File: rtl/burst_sram_wr.sv
`timescale 1ns/1ps
module burst_sram_wr #(
  parameter int ADDR_W  = 10,
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    cpu_strobe_n,
  input  logic                    ctl_strobe_n,
  input  logic                    burst_adv_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    sel_gate_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b_n,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_drive
);
  logic [ADDR_W-1:0] cyc_addr;
  logic [ADDR_W-1:0] burst_q;
  logic [LANES-1:0]  wr_lanes;
  logic              rd_en;
  logic              active_q;

  bsr_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .addr         (addr),
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .burst_adv_n  (burst_adv_n),
    .wr_all_n     (wr_all_n),
    .wr_byte_n    (wr_byte_n),
    .lane_wr_n    (lane_wr_n),
    .sel_gate_n   (sel_gate_n),
    .sel_a_n      (sel_a_n),
    .sel_b_n      (sel_b_n),
    .cyc_addr     (cyc_addr),
    .wr_lanes     (wr_lanes),
    .rd_en        (rd_en),
    .active_q     (active_q),
    .burst_q      (burst_q)
  );

  bsr_lanes #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) lanes_i (
    .clk      (clk),
    .addr     (cyc_addr),
    .wr_lanes (wr_lanes),
    .wdata    (wdata),
    .rd_en    (rd_en),
    .rd_data  (rdata)
  );

  bsr_out out_i (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .out_en_n (out_en_n),
    .drive_q  (rdata_drive)
  );
endmodule

// File: rtl/burst_sram_wr_chk.sv
`timescale 1ns/1ps
module burst_sram_wr_chk #(
  parameter int ADDR_W  = 10,
  parameter int LANES   = 4,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              cpu_strobe_n,
  input logic              ctl_strobe_n,
  input logic              burst_adv_n,
  input logic              wr_all_n,
  input logic              wr_byte_n,
  input logic              sel_gate_n,
  input logic              rdata_drive,
  input logic [LANES-1:0]  wr_lanes,
  input logic              active_q,
  input logic [ADDR_W-1:0] burst_q
);
  p_cpu_start_no_write_r1: assert property (@(posedge clk) disable iff (rst)
    (!cpu_strobe_n && !sel_gate_n) |-> (wr_lanes == '0));

  p_gated_strobe_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (!cpu_strobe_n && sel_gate_n && ctl_strobe_n && burst_adv_n)
      |=> (burst_q == $past(burst_q)) && (active_q == $past(active_q)));

  p_ctl_strobe_loads_r3: assert property (@(posedge clk) disable iff (rst)
    (!ctl_strobe_n && (cpu_strobe_n || sel_gate_n)) |=> (burst_q == $past(addr)));

  p_idle_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    (!active_q && cpu_strobe_n && ctl_strobe_n) |-> (wr_lanes == '0));

  p_deselect_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (!active_q && cpu_strobe_n && ctl_strobe_n) |=> !active_q);

  p_burst_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (active_q && cpu_strobe_n && ctl_strobe_n && !burst_adv_n)
      |=> (burst_q[BURST_W-1:0] == BURST_W'($past(burst_q[BURST_W-1:0]) + 1'b1))
          && (burst_q[ADDR_W-1:BURST_W] == $past(burst_q[ADDR_W-1:BURST_W])));

  p_global_all_lanes_r6: assert property (@(posedge clk) disable iff (rst)
    (active_q && cpu_strobe_n && ctl_strobe_n && !wr_all_n) |-> (wr_lanes == '1));

  p_no_enable_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_all_n && wr_byte_n) |-> (wr_lanes == '0));

  p_hiz_after_write_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_lanes != '0) |=> !rdata_drive);
endmodule

bind burst_sram_wr burst_sram_wr_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .addr         (addr),
  .cpu_strobe_n (cpu_strobe_n),
  .ctl_strobe_n (ctl_strobe_n),
  .burst_adv_n  (burst_adv_n),
  .wr_all_n     (wr_all_n),
  .wr_byte_n    (wr_byte_n),
  .sel_gate_n   (sel_gate_n),
  .rdata_drive  (rdata_drive),
  .wr_lanes     (wr_lanes),
  .active_q     (active_q),
  .burst_q      (burst_q)
);

// File: tb/burst_sram_wr_tb_top.sv
`timescale 1ns/1ps
module burst_sram_wr_tb_top;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic          cpu_strobe_n, ctl_strobe_n, burst_adv_n;
  logic          wr_all_n, wr_byte_n;
  logic [3:0]    lane_wr_n;
  logic          sel_gate_n, sel_a_n, sel_b_n, out_en_n;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic          rdata_drive;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0]   m_mem [DEPTH];
  logic          m_act;
  logic [AW-1:0] m_burst;

  always #2.5 clk = ~clk;

  burst_sram_wr #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .addr(addr),
    .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
    .burst_adv_n(burst_adv_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .lane_wr_n(lane_wr_n), .sel_gate_n(sel_gate_n), .sel_a_n(sel_a_n),
    .sel_b_n(sel_b_n), .out_en_n(out_en_n), .wdata(wdata),
    .rdata(rdata), .rdata_drive(rdata_drive)
  );

  function automatic logic [31:0] pat(input int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h00C3A5E1;
  endfunction

  task automatic clr();
    cpu_strobe_n = 1; ctl_strobe_n = 1; burst_adv_n = 1;
    wr_all_n = 1; wr_byte_n = 1; lane_wr_n = 4'hF;
    sel_gate_n = 0; sel_a_n = 0; sel_b_n = 0; out_en_n = 0;
    wdata = '0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: model the cycle from the requirements, then compare outputs.
  task automatic tick(input string tag);
    logic p, s, seln, csel, rd, wrote, exp_oe;
    logic [AW-1:0] ca;
    logic [3:0] req, ln;
    logic [31:0] exp_d;
    p    = !cpu_strobe_n && !sel_gate_n;
    s    = p || !ctl_strobe_n;
    seln = !sel_gate_n && !sel_a_n && !sel_b_n;
    csel = s ? seln : m_act;
    if (s) ca = addr;
    else if (m_act && !burst_adv_n) ca = {m_burst[AW-1:2], m_burst[1:0] + 2'd1};
    else ca = m_burst;
    req = !wr_all_n ? 4'hF : (!wr_byte_n ? ~lane_wr_n : 4'h0);
    ln  = (csel && !p) ? req : 4'h0;
    rd  = csel && (p || req == 4'h0);
    wrote  = (ln != 4'h0);
    exp_oe = rd && !out_en_n;
    exp_d  = m_mem[ca];
    for (int i = 0; i < 4; i++)
      if (ln[i]) m_mem[ca][i*8 +: 8] = wdata[i*8 +: 8];
    m_act = csel; m_burst = ca;
    @(posedge clk); #1;
    chk(wrote || !csel ? "R9 drive" : {tag, " drive"}, 32'(rdata_drive), 32'(exp_oe));
    if (exp_oe) chk({tag, " R8 data"}, rdata, exp_d);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    clr(); rst = 1; m_act = 0; m_burst = '0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    repeat (4) @(posedge clk);
    #1;
    chk("R10 drive in reset", 32'(rdata_drive), 0);
    rst = 0;
    clr(); tick("R10");

    // Fill: controller-strobed global-write bursts (R3, R5, R6).
    for (int g = 0; g < DEPTH / 4; g++) begin
      clr(); ctl_strobe_n = 0; addr = AW'(g * 4); wr_all_n = 0;
      wr_byte_n = 1; lane_wr_n = 4'h0; wdata = pat(g * 4); tick("R6");
      for (int k = 1; k < 4; k++) begin
        clr(); burst_adv_n = 0; wr_all_n = 0; wdata = pat(g * 4 + k); tick("R5");
      end
    end

    // R5: read burst from 8 wraps back to 8 after 11.
    clr(); cpu_strobe_n = 0; addr = 8; tick("R1");
    chk("R8 read at 8", rdata, pat(8));
    for (int k = 1; k <= 4; k++) begin
      clr(); burst_adv_n = 0; tick("R5");
      chk("R5 wrap", rdata, pat(8 + (k % 4)));
    end
    // R5: start on last word of a group.
    clr(); ctl_strobe_n = 0; addr = 23; tick("R5");
    clr(); burst_adv_n = 0; tick("R5");
    chk("R5 wrap from 23", rdata, pat(20));

    // R2: gated processor strobe does not reload the counter.
    clr(); cpu_strobe_n = 0; addr = 32; tick("R2");
    clr(); cpu_strobe_n = 0; sel_gate_n = 1; addr = 40; tick("R2");
    chk("R2 gated strobe ignored", rdata, pat(32));
    clr(); burst_adv_n = 0; tick("R2");
    chk("R2 burst continues", rdata, pat(33));

    // R4: deselect via sel_a_n on a strobe, then write beats do nothing.
    clr(); ctl_strobe_n = 0; sel_a_n = 1; addr = 60; wr_all_n = 0; wdata = 32'hDEADBEEF; tick("R4");
    for (int k = 0; k < 2; k++) begin
      clr(); burst_adv_n = 0; wr_all_n = 0; wdata = 32'hDEADBEEF; tick("R4");
    end
    clr(); cpu_strobe_n = 0; sel_b_n = 1; addr = 64; tick("R4");
    clr(); wr_all_n = 0; wdata = 32'hDEADBEEF; tick("R4");
    clr(); ctl_strobe_n = 0; addr = 60; tick("R4");
    chk("R4 no write while deselected", rdata, pat(60));
    clr(); ctl_strobe_n = 0; addr = 64; tick("R4");
    chk("R4 no write after deselect", rdata, pat(64));

    // R1: processor start ignores write inputs; next beat writes.
    clr(); cpu_strobe_n = 0; addr = 100; wr_byte_n = 0; lane_wr_n = 4'h0; wdata = 32'h12345678; tick("R1");
    chk("R1 start cycle reads old", rdata, pat(100));
    clr(); wr_all_n = 0; wdata = 32'h0BADF00D; tick("R1");
    clr(); ctl_strobe_n = 0; addr = 100; tick("R1");
    chk("R1 first data beat written", rdata, 32'h0BADF00D);

    // R3: both strobes, processor wins, so no write at 120.
    clr(); cpu_strobe_n = 0; ctl_strobe_n = 0; addr = 120; wr_all_n = 0; wdata = 32'hFFFFFFFF; tick("R3");
    clr(); ctl_strobe_n = 0; addr = 120; tick("R3");
    chk("R3 priority", rdata, pat(120));

    // R6 / R7: lane masks.
    clr(); ctl_strobe_n = 0; addr = 12; wr_all_n = 0; wdata = 32'h11223344; tick("R6");
    clr(); ctl_strobe_n = 0; addr = 12; wr_byte_n = 0; lane_wr_n = 4'b0101; wdata = 32'hAABBCCDD; tick("R7");
    clr(); ctl_strobe_n = 0; addr = 12; wr_byte_n = 1; lane_wr_n = 4'h0; wdata = 32'h0; tick("R7");
    chk("R7 lane merge", rdata, 32'hAA22CC44);
    clr(); ctl_strobe_n = 0; addr = 13; wr_all_n = 0; wr_byte_n = 1; lane_wr_n = 4'hF; wdata = 32'h5A5A5A5A; tick("R6");
    clr(); ctl_strobe_n = 0; addr = 13; tick("R6");
    chk("R6 global write", rdata, 32'h5A5A5A5A);

    // Random traffic.
    for (int n = 0; n < 3000; n++) begin
      clr();
      addr         = AW'($urandom);
      cpu_strobe_n = ($urandom % 100) >= 15;
      ctl_strobe_n = ($urandom % 100) >= 15;
      sel_gate_n   = ($urandom % 100) >= 85;
      sel_a_n      = ($urandom % 100) >= 90;
      sel_b_n      = ($urandom % 100) >= 90;
      burst_adv_n  = ($urandom % 100) >= 60;
      wr_all_n     = ($urandom % 100) >= 20;
      wr_byte_n    = ($urandom % 100) >= 40;
      lane_wr_n    = 4'($urandom);
      out_en_n     = ($urandom % 100) >= 80;
      wdata        = $urandom;
      tick("R8");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule